// File: doc/BRIEF.md
# Runtime-Programmable CIC Decimator

This block lowers the sample rate of a complex I/Q stream with a fourth-order cascaded integrator-comb filter whose differential delay is one. The decimation ratio is not fixed at build time. A 16-bit control word sets it while the block runs. The low byte of that word is the CIC ratio R. The byte above it is a count of downstream decimate-by-2 half-band stages, which the block passes on to the next stage of the chain.

Input samples are qualified by a valid strobe, and gaps of any length are allowed. For every R accepted samples the block emits one filtered output pair with a one-cycle valid strobe. The filter's gain of R^4 is brought back to unity or below by an arithmetic right shift of ceil(log2(R^4)) bits. Any change of the control word starts the filter again from an empty state. A constant output port reports the largest CIC ratio the build supports, so that rate-selection software can check a request before it writes the word.

Top module: `cic_decim_top`

## Requirements
- R1: After reset the block runs at a 1:1 rate, as if the control word were 16'h0001. out_valid is 0 and hb_stages is 0 while reset is applied and in the cycles after it, before any sample has been accepted.
- R2: The CIC ratio R is ctrl_word[7:0]. Exactly one output pair is produced for every R input samples accepted with in_valid high, and gaps in in_valid do not change this count.
- R3: Each output is the fourth-order CIC response with differential delay 1. The k-th output after a restart (k from 0) is y = sum over j of h[j]·x[kR+R-1-j], where h is four boxcars of length R convolved together and samples before the restart count as zero.
- R4: The output is floor(y / 2^S), the low 16 bits of the arithmetic right shift of y by S = ceil(log2(R^4)). For example S is 0 for R=1, 10 for R=5 and 20 for R=32.
- R5: hb_stages equals ctrl_word[15:8] unless the effective R is odd and greater than 1. In that case hb_stages is 0.
- R6: An R field of 0 is treated as R=1. An R field above RMAX is treated as R=RMAX. The effective R is always between 1 and RMAX.
- R7: rmax_rd always reads RMAX.
- R8: Any change of ctrl_word clears the integrator, comb and counter state. A sample presented in the cycle of the change is discarded, and an output that was still in flight is dropped.
- R9: The integrators use wrap-around arithmetic that is IN_W + 4·ceil(log2(RMAX)) bits wide. Outputs stay exact on long full-scale runs at R=RMAX, where the integrators overflow.
- R10: out_valid is high for exactly one cycle per output. It rises in the second clock cycle after the edge that accepted the R-th sample of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 16 | Bits 7:0 CIC ratio, bits 15:8 half-band stage count |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | IN_W | In-phase input sample, signed |
| in_q | input | IN_W | Quadrature input sample, signed |
| out_valid | output | 1 | One-cycle strobe for each decimated output |
| out_i | output | OUT_W | In-phase output, signed |
| out_q | output | OUT_W | Quadrature output, signed |
| hb_stages | output | 8 | Half-band stage count for the downstream filters |
| rmax_rd | output | 8 | Largest supported CIC ratio |

## Verification
Random samples with random valid gaps are run at several ratios, both even and odd, and the result is compared with a direct FIR model. This separates a correct integrator/comb pairing and grouping of samples from any error in sample counting or stage ordering.

A single impulse at R=4 brings out the impulse response term by term. Full-scale constant runs at R=RMAX make the integrators wrap, and show whether the modular arithmetic and the shift of exactly 20 bits give the input value back unchanged. Three more directed cases cover the boundaries: control words with R=0 and R above RMAX, an odd R with a nonzero half-band field, and a reconfiguration in the middle of a block with a sample in the same cycle. These check the clamping, the half-band forcing and the flush.

// File: rtl/cic_pkg.sv
// Shared constants and helpers for the CIC decimator.
// Assumes ratios fit in 8 bits, so R^4 fits in 40 bits.
package cic_pkg;
    localparam int CIC_ORDER = 4;
    localparam int CTRL_W    = 16;
    localparam int RFIELD_W  = 8;
    localparam int SHIFT_W   = 6;

    // Smallest s such that 2^s >= r^4, which is the normalising shift.
    function automatic logic [SHIFT_W-1:0] gain_shift(input logic [RFIELD_W-1:0] r);
        logic [39:0] p;
        p = 40'(r) * 40'(r);
        p = p * 40'(r);
        p = p * 40'(r);
        gain_shift = '0;
        for (int s = 39; s >= 0; s--) begin
            if ((40'd1 << s) >= p) gain_shift = SHIFT_W'(s);
        end
    endfunction
endpackage

// File: rtl/cic_cfg.sv
// Configuration register for the decimator.
// It holds the last control word and derives the effective ratio (clamped to
// 1..RMAX), the normalising shift and the half-band count from it. It raises
// flush in any cycle where the input word differs from the stored word.
// Assumes 1 <= RMAX <= 255.
module cic_cfg
    import cic_pkg::*;
#(
    parameter int RMAX = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTRL_W-1:0]   ctrl_word,
    output logic                flush,
    output logic [RFIELD_W-1:0] r_val,
    output logic [SHIFT_W-1:0]  shift,
    output logic [7:0]          hb_cnt
);
    localparam logic [RFIELD_W-1:0] RMAX_V = RFIELD_W'(RMAX);

    logic [CTRL_W-1:0]   cfg_q;
    logic [RFIELD_W-1:0] r_q, r_eff;
    logic [SHIFT_W-1:0]  shift_q;
    logic [7:0]          hb_q, hb_d;

    // Clamp the ratio field and decide the forwarded half-band count.
    always_comb begin
        if (ctrl_word[RFIELD_W-1:0] == '0)
            r_eff = RFIELD_W'(1);
        else if (ctrl_word[RFIELD_W-1:0] > RMAX_V)
            r_eff = RMAX_V;
        else
            r_eff = ctrl_word[RFIELD_W-1:0];
        hb_d = (r_eff[0] && (r_eff != RFIELD_W'(1))) ? 8'd0 : ctrl_word[15:8];
    end

    assign flush = (ctrl_word != cfg_q);

    // Latch a new configuration; the reset value gives a 1:1 rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= CTRL_W'(16'h0001);
            r_q     <= RFIELD_W'(1);
            shift_q <= '0;
            hb_q    <= '0;
        end else if (flush) begin
            cfg_q   <= ctrl_word;
            r_q     <= r_eff;
            shift_q <= gain_shift(r_eff);
            hb_q    <= hb_d;
        end
    end

    assign r_val  = r_q;
    assign shift  = shift_q;
    assign hb_cnt = hb_q;

    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q != '0) && (r_q <= RMAX_V));
    p_hb_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q[0] && (r_q != RFIELD_W'(1))) |-> (hb_q == 8'd0));
    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cfg_q == $past(ctrl_word)));
endmodule

// File: rtl/cic_rate_ctr.sv
// Decimation counter.
// It counts accepted samples modulo R and pulses tick one cycle after the
// R-th sample of each group. flush restarts it from zero.
// Assumes r_val is at least 1.
module cic_rate_ctr
    import cic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                en,
    input  logic [RFIELD_W-1:0] r_val,
    output logic                tick
);
    logic [RFIELD_W-1:0] cnt_q;
    logic                tick_q;
    logic                last;

    assign last = (cnt_q == (r_val - RFIELD_W'(1)));

    // Advance the count on each accepted sample and mark the end of a group.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= en && last;
            if (en) cnt_q <= last ? '0 : cnt_q + RFIELD_W'(1);
        end
    end

    assign tick = tick_q;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < r_val);
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0) && !tick_q);
    p_tick_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> $past(en));
endmodule

// File: rtl/cic_integ.sv
// Integrator cascade for one lane.
// CIC_ORDER wrap-around accumulators are chained on their next values, so that
// after the n-th accepted sample the last stage holds the fourth running sum
// up to and including that sample. flush clears all stages.
// Assumes ACC_W >= IN_W.
module cic_integ
    import cic_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             en,
    input  logic [IN_W-1:0]  din,
    output logic [ACC_W-1:0] acc_out
);
    logic [ACC_W-1:0] ext;

    assign ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

    for (genvar k = 0; k < CIC_ORDER; k++) begin : g_st
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] nxt;
        if (k == 0) begin : g_first
            assign nxt = acc_q + ext;
        end else begin : g_next
            assign nxt = acc_q + g_st[k-1].nxt;
        end
        // Accumulate this stage on each accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) acc_q <= '0;
            else if (en)         acc_q <= nxt;
        end
    end

    assign acc_out = g_st[CIC_ORDER-1].acc_q;

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (acc_out == '0));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush) |=> $stable(acc_out));
endmodule

// File: rtl/cic_comb.sv
// Comb cascade and gain normaliser for one lane.
// On each decimation tick it takes the integrator output through CIC_ORDER
// first differences (delay 1 at the low rate), shifts the result right
// arithmetically by `shift` and registers the low OUT_W bits.
// Assumes that shift normalises R^4, so the scaled value fits in OUT_W.
module cic_comb
    import cic_pkg::*;
#(
    parameter int ACC_W = 36,
    parameter int OUT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               en,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [ACC_W-1:0]   din,
    output logic [OUT_W-1:0]   dout
);
    logic signed [ACC_W-1:0] scaled;
    logic [OUT_W-1:0]        dout_q;

    for (genvar k = 0; k < CIC_ORDER; k++) begin : g_st
        logic [ACC_W-1:0] stage_in;
        logic [ACC_W-1:0] dly_q;
        logic [ACC_W-1:0] diff;
        if (k == 0) begin : g_first
            assign stage_in = din;
        end else begin : g_next
            assign stage_in = g_st[k-1].diff;
        end
        assign diff = stage_in - dly_q;
        // Keep the previous low-rate value of this stage's input.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) dly_q <= '0;
            else if (en)         dly_q <= stage_in;
        end
    end

    assign scaled = $signed(g_st[CIC_ORDER-1].diff) >>> shift;

    // Register the normalised output on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) dout_q <= '0;
        else if (en)         dout_q <= scaled[OUT_W-1:0];
    end

    assign dout = dout_q;

    p_out_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (dout_q == '0));
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush) |=> $stable(dout_q));
endmodule

// File: rtl/cic_decim_top.sv
// Runtime-programmable fourth-order CIC decimator for complex samples.
// ctrl_word[7:0] selects the ratio R and ctrl_word[15:8] the downstream
// half-band count. One output pair comes out per R accepted samples, scaled
// down by 2^ceil(log2(R^4)). Any change of the control word restarts the filter.
// Assumes 1 <= RMAX <= 255 and OUT_W <= IN_W + 4*ceil(log2(RMAX)).
module cic_decim_top
    import cic_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int RMAX  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       ctrl_word,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_i,
    input  logic [IN_W-1:0]   in_q,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    output logic [7:0]        hb_stages,
    output logic [7:0]        rmax_rd
);
    localparam int GROWTH = CIC_ORDER * $clog2(RMAX);
    localparam int ACC_W  = IN_W + GROWTH;
    localparam int LANES  = 2;

    logic                flush;
    logic [RFIELD_W-1:0] r_val;
    logic [SHIFT_W-1:0]  shift;
    logic                accept;
    logic                tick;
    logic                comb_en;
    logic                valid_q;
    logic [IN_W-1:0]     lane_in  [LANES];
    logic [OUT_W-1:0]    lane_out [LANES];

    assign accept  = in_valid && !flush;
    assign comb_en = tick && !flush;

    cic_cfg #(.RMAX(RMAX)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .flush     (flush),
        .r_val     (r_val),
        .shift     (shift),
        .hb_cnt    (hb_stages)
    );

    cic_rate_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .en    (accept),
        .r_val (r_val),
        .tick  (tick)
    );

    assign lane_in[0] = in_i;
    assign lane_in[1] = in_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ACC_W-1:0] acc;
        cic_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .en      (accept),
            .din     (lane_in[l]),
            .acc_out (acc)
        );
        cic_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .en    (comb_en),
            .shift (shift),
            .din   (acc),
            .dout  (lane_out[l])
        );
    end

    // Strobe out_valid in the cycle after each surviving tick.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= comb_en;
    end

    assign out_valid = valid_q;
    assign out_i     = lane_out[0];
    assign out_q     = lane_out[1];
    assign rmax_rd   = 8'(RMAX);

    p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tick && !flush));
    p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid || $past(tick));
    p_no_valid_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);
endmodule

// File: tb/cic_decim_top_tb.sv
// Self-checking bench for cic_decim_top. A negedge monitor models every
// accepted sample with a direct FIR and matches outputs in value and cycle.
module cic_decim_top_tb;
    localparam int IN_W = 16, OUT_W = 16, RMAX = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [15:0]       ctrl_word;
    logic              in_valid;
    logic [IN_W-1:0]   in_i, in_q;
    logic              out_valid;
    logic [OUT_W-1:0]  out_i, out_q;
    logic [7:0]        hb_stages, rmax_rd;

    cic_decim_top #(.IN_W(IN_W), .OUT_W(OUT_W), .RMAX(RMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
        .out_q(out_q), .hb_stages(hb_stages), .rmax_rd(rmax_rd)
    );

    int errors = 0, checks = 0, ncyc = 0;
    string phase_tag = "R1";
    longint hist_i[$], hist_q[$];
    longint h[1024];
    int hlen;
    int m_r, m_shift;
    logic [15:0] m_cfg;
    longint exp_i[$], exp_q[$];
    int exp_due[$];

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int eff_r(logic [7:0] raw);
        if (raw == 8'd0) return 1;
        if (int'(raw) > RMAX) return RMAX;
        return int'(raw);
    endfunction

    function automatic int shift_of(int r);
        longint p = longint'(r) * r * r * r;
        int s = 0;
        while ((64'sd1 <<< s) < p) s++;
        return s;
    endfunction

    function automatic int exp_hb(logic [15:0] w);
        int r = eff_r(w[7:0]);
        return ((r % 2 == 1) && r > 1) ? 0 : int'(w[15:8]);
    endfunction

    // Four boxcars of length r convolved together.
    function automatic void build_h(int r);
        longint b[1024];
        int len = 1;
        h[0] = 1;
        for (int st = 0; st < 4; st++) begin
            for (int m = 0; m < len + r - 1; m++) begin
                b[m] = 0;
                for (int i = 0; i < r; i++)
                    if (m - i >= 0 && m - i < len) b[m] += h[m - i];
            end
            len = len + r - 1;
            for (int m = 0; m < len; m++) h[m] = b[m];
        end
        hlen = len;
    endfunction

    function automatic void apply_cfg(logic [15:0] w);
        m_cfg = w;
        m_r = eff_r(w[7:0]);
        m_shift = shift_of(m_r);
        build_h(m_r);
        hist_i.delete();
        hist_q.delete();
    endfunction

    function automatic longint filt(bit lane);
        longint y = 0;
        int n = hist_i.size();
        logic signed [OUT_W-1:0] t;
        for (int j = 0; j < hlen; j++)
            if (n - 1 - j >= 0) y += h[j] * (lane ? hist_q[n-1-j] : hist_i[n-1-j]);
        t = OUT_W'(y >>> m_shift);
        return longint'(t);
    endfunction

    // Monitor: match outputs, then model the inputs sampled at the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            if (out_valid) begin
                if (exp_due.size() == 0) begin
                    chk(1'b0, {phase_tag, " R2 unexpected output"}, 1, 0);
                end else begin
                    chk(ncyc == exp_due[0], {phase_tag, " R10 output cycle"}, ncyc, exp_due[0]);
                    chk(longint'($signed(out_i)) == exp_i[0], {phase_tag, " R3 R4 I value"},
                        longint'($signed(out_i)), exp_i[0]);
                    chk(longint'($signed(out_q)) == exp_q[0], {phase_tag, " R3 R4 Q value"},
                        longint'($signed(out_q)), exp_q[0]);
                    void'(exp_due.pop_front());
                    void'(exp_i.pop_front());
                    void'(exp_q.pop_front());
                end
            end else if (exp_due.size() > 0 && exp_due[0] <= ncyc) begin
                chk(1'b0, {phase_tag, " R2 missing output"}, ncyc, exp_due[0]);
                void'(exp_due.pop_front());
                void'(exp_i.pop_front());
                void'(exp_q.pop_front());
            end
            if (ctrl_word != m_cfg) begin
                while (exp_due.size() > 0 && exp_due[$] > ncyc) begin
                    void'(exp_due.pop_back());
                    void'(exp_i.pop_back());
                    void'(exp_q.pop_back());
                end
                apply_cfg(ctrl_word);
            end else if (in_valid) begin
                hist_i.push_back(longint'($signed(in_i)));
                hist_q.push_back(longint'($signed(in_q)));
                if (hist_i.size() % m_r == 0) begin
                    exp_i.push_back(filt(1'b0));
                    exp_q.push_back(filt(1'b1));
                    exp_due.push_back(ncyc + 2);
                end
            end
        end
    end

    task automatic drive(bit v, logic [IN_W-1:0] di, logic [IN_W-1:0] dq);
        @(posedge clk);
        #1;
        in_valid = v;
        in_i = di;
        in_q = dq;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, '0);
    endtask

    task automatic send_rand(int n, int gap_pct);
        for (int i = 0; i < n; i++) begin
            if (int'($urandom % 100) < gap_pct) drive(1'b0, '0, '0);
            drive(1'b1, IN_W'($urandom), IN_W'($urandom));
        end
    endtask

    task automatic set_ctrl(logic [15:0] w, string tag);
        @(posedge clk);
        #1;
        ctrl_word = w;
        in_valid = 1'b0;
        idle(3);
        #2;
        chk(int'(hb_stages) == exp_hb(w), {tag, " R5 half-band count"}, hb_stages, exp_hb(w));
    endtask

    task automatic drain(string tag);
        idle(8);
        chk(exp_due.size() == 0, {tag, " R2 all outputs emitted"}, exp_due.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        ctrl_word = 16'h0001;
        in_valid = 1'b0;
        in_i = '0;
        in_q = '0;
        apply_cfg(16'h0001);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(hb_stages == 8'd0, "R1 hb_stages in reset", hb_stages, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        #2;
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(hb_stages == 8'd0, "R1 hb_stages after reset", hb_stages, 0);
        chk(rmax_rd == 8'(RMAX), "R7 rmax readback", rmax_rd, RMAX);

        phase_tag = "R1 default 1:1";
        send_rand(40, 30);
        drain(phase_tag);

        phase_tag = "R3 impulse R=4";
        set_ctrl(16'h0204, phase_tag);
        drive(1'b1, IN_W'(1000), IN_W'(-1000));
        for (int i = 0; i < 15; i++) drive(1'b1, '0, '0);
        send_rand(64, 30);
        drain(phase_tag);

        phase_tag = "R5 odd R=5";
        set_ctrl(16'h0305, phase_tag);
        send_rand(60, 20);
        drain(phase_tag);

        phase_tag = "R6 zero ratio";
        set_ctrl(16'h0700, phase_tag);
        send_rand(20, 0);
        drain(phase_tag);

        phase_tag = "R6 ratio above max";
        set_ctrl(16'h01C8, phase_tag);
        send_rand(96, 10);
        drain(phase_tag);

        phase_tag = "R9 wrap full scale";
        set_ctrl(16'h0020, phase_tag);
        for (int i = 0; i < 320; i++) drive(1'b1, IN_W'(32767), IN_W'(-32768));
        for (int i = 0; i < 320; i++) drive(1'b1, IN_W'(-32768), IN_W'(32767));
        drain(phase_tag);

        phase_tag = "R8 flush mid block";
        set_ctrl(16'h0008, phase_tag);
        for (int i = 0; i < 13; i++) drive(1'b1, IN_W'($urandom), IN_W'($urandom));
        @(posedge clk);
        #1;
        ctrl_word = 16'h0003;
        in_valid = 1'b1;
        in_i = IN_W'(12345);
        in_q = IN_W'(-12345);
        send_rand(30, 0);
        drain(phase_tag);

        phase_tag = "R2 random ratios";
        for (int k = 0; k < 6; k++) begin
            logic [15:0] w;
            w = {8'($urandom % 4), 8'(1 + ($urandom % RMAX))};
            set_ctrl(w, phase_tag);
            send_rand(4 * eff_r(w[7:0]) + 7, 25);
            drain(phase_tag);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule